// File: doc/BRIEF.md
# Breakpoint Match and Linking Unit

This unit keeps six breakpoint slots. Each slot has a 32-bit value word and a 32-bit control word. On every valid instruction fetch, each slot compares its value with the fetch address or with the current context ID, and checks the processor privilege level against a per-slot condition. It then reports whether a breakpoint event should be raised. A 3-bit type field in each control word picks the test. The test can be an exact address hit or an address miss, each either on its own or gated by another slot's context comparison. It can also be a context-ID comparison that either raises its own event or only serves as a link target.

Software-side logic loads the slots through a plain write port. The fetch stage supplies a valid strobe, the address, the access size, the privilege level and the context ID. Events come out registered, one cycle after the fetch, both per slot and as a single combined flag. Every slot also drives a live context-match flag, so that data-watchpoint logic outside this unit can use a context slot as its link target.

Top module: `bpMatchUnit`

## Requirements
- R1: After reset, all value and control words are zero, `evtVec` and `evtAny` are 0, and `ctxMatchOut` is 0.
- R2: When `wrEn` is 1, `wrData` is stored into slot `wrIdx`: into the control word if `wrCtl`=1, otherwise into the value word. A write with `wrIdx` ≥ 6 changes nothing.
- R3: `evtVec` shows the slot results of the fetch sampled at the previous clock edge. Both `evtVec` and `evtAny` are 0 in the cycle after an edge where `fetchValid` was 0.
- R4: Control field layout: [0] enable, [2:1] privilege condition, [8:5] lane mask, [15:14] reserved, which must be zero for a context link target, [19:16] link index, [22:20] type. Type 000 fires when value[31:2] equals fetchAddr[31:2] and the privilege condition holds.
- R5: The privilege condition uses these codes: 00 never holds; 01 holds only when `privMode`=1 (privileged); 10 holds only when `privMode`=0 (user); 11 always holds.
- R6: A slot whose enable bit [0] is 0 raises no event and drives no context-match flag.
- R7: Type 001 fires under the type 000 condition, and only if the linked slot's context-match flag is also 1.
- R8: Type 010 fires when all 32 value bits equal `ctxId`, the privilege condition holds, and the lane mask is 1111. With any other lane mask it never fires.
- R9: Type 011 never fires. It drives `ctxMatchOut` to 1, combinationally from the current `ctxId`, when it is enabled, its value equals `ctxId`, its privilege code is 11, its lane mask is 1111 and bits [15:14] are 00.
- R10: Type 100 fires when the fetch misses and the privilege condition holds. A hit needs both of these: equal address words, and at least one lane that lies both in the lane mask and in the fetched lanes. A word fetch (`fetchSize`=1) covers lanes 1111. A halfword fetch covers lanes 0011 when fetchAddr[1]=0 and lanes 1100 when fetchAddr[1]=1.
- R11: Type 101 fires under the type 100 condition, and only if the linked slot's context-match flag is 1.
- R12: A link index of 6 or more, or one that names a slot whose context-match flag is 0, blocks a linked event. Types 110 and 111 never fire.
- R13: `evtAny` is the OR of all bits of `evtVec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrCtl | input | 1 | 1 selects the control word, 0 selects the value word |
| wrIdx | input | 3 | Target slot index |
| wrData | input | 32 | Write data |
| fetchValid | input | 1 | Instruction fetch present |
| fetchAddr | input | 32 | Fetch address |
| fetchSize | input | 1 | 1 = word fetch, 0 = halfword fetch |
| privMode | input | 1 | 1 = privileged, 0 = user |
| ctxId | input | 32 | Current context ID |
| evtVec | output | 6 | Registered per-slot breakpoint events |
| evtAny | output | 1 | Registered OR of all events |
| ctxMatchOut | output | 6 | Live per-slot context-match flags for link users |

## Verification
The bench sweeps slot 0 through every type code. For each type it covers every privilege code, both privilege levels, enable on and off, an address hit and an address miss, and three context values, while slot 1 acts as a valid context target. This separates hit from miss, privilege from user, and standalone from linked behaviour. A second sweep runs all sixteen lane masks against word and halfword fetches on both halves of a word, which tests the lane qualification of a miss. A third sweep tries all sixteen link indices against a context slot that is valid, disabled, wrongly restricted by privilege, marked in the reserved bits, or narrowed in its lane mask, which tests how a link target is accepted. Writes to slot indices 6 and 7 are then shown to leave every output unchanged.

// File: rtl/bpMatchPkg.sv
package bpMatchPkg;
  localparam int MAX_PAIRS = 16;
  localparam int DATA_W    = 32;

  typedef enum logic [2:0] {
    TY_ADDR      = 3'b000,
    TY_ADDR_LNK  = 3'b001,
    TY_CTX       = 3'b010,
    TY_CTX_SRC   = 3'b011,
    TY_MISS      = 3'b100,
    TY_MISS_LNK  = 3'b101
  } bpType_e;

  typedef struct packed {
    logic [MAX_PAIRS-1:0] valWe;
    logic [MAX_PAIRS-1:0] ctlWe;
    logic                 capture;
  } bpStrobe_t;
endpackage

// File: rtl/bpMatchCtrl.sv
module bpMatchCtrl
  import bpMatchPkg::*;
#(
  parameter int NUM_PAIRS = 6,
  parameter int IDX_W     = 3
) (
  input  logic             wrEn,
  input  logic             wrCtl,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             fetchValid,
  output bpStrobe_t        strobes
);
  always_comb begin
    strobes = '0;
    strobes.capture = fetchValid;
    for (int i = 0; i < NUM_PAIRS; i++) begin
      strobes.valWe[i] = wrEn && !wrCtl && (wrIdx == IDX_W'(i));
      strobes.ctlWe[i] = wrEn &&  wrCtl && (wrIdx == IDX_W'(i));
    end
  end
endmodule

// File: rtl/bpMatchPath.sv
module bpMatchPath
  import bpMatchPkg::*;
#(
  parameter int NUM_PAIRS = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  bpStrobe_t            strobes,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [DATA_W-1:0]    fetchAddr,
  input  logic                 fetchSize,
  input  logic                 privMode,
  input  logic [DATA_W-1:0]    ctxId,
  output logic [NUM_PAIRS-1:0] evtVec,
  output logic                 evtAny,
  output logic [NUM_PAIRS-1:0] ctxMatchOut
);
  logic [DATA_W-1:0]    valReg [NUM_PAIRS];
  logic [DATA_W-1:0]    ctlReg [NUM_PAIRS];
  logic [NUM_PAIRS-1:0] ctxFlag;
  logic [NUM_PAIRS-1:0] evtComb;
  logic [MAX_PAIRS-1:0] ctxPad;
  logic [3:0]           fetchLanes;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_PAIRS; i++) begin
      if (rst) begin
        valReg[i] <= '0;
        ctlReg[i] <= '0;
      end else begin
        if (strobes.valWe[i]) valReg[i] <= wrData;
        if (strobes.ctlWe[i]) ctlReg[i] <= wrData;
      end
    end
  end

  // lanes touched by this fetch
  always_comb begin
    if (fetchSize)         fetchLanes = 4'b1111;
    else if (fetchAddr[1]) fetchLanes = 4'b1100;
    else                   fetchLanes = 4'b0011;
  end

  assign ctxPad = MAX_PAIRS'(ctxFlag);

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : gPair
    logic       slotOn, stateOk, wordEq, laneHit, ctxEq, linkOk;
    logic [1:0] privCode;
    logic [3:0] laneMask;
    logic [3:0] linkIdx;
    bpType_e    kind;

    assign slotOn   = ctlReg[g][0];
    assign privCode = ctlReg[g][2:1];
    assign laneMask = ctlReg[g][8:5];
    assign linkIdx  = ctlReg[g][19:16];
    assign kind     = bpType_e'(ctlReg[g][22:20]);

    assign stateOk = (privCode == 2'b11) ||
                     (privCode == 2'b01 &&  privMode) ||
                     (privCode == 2'b10 && !privMode);
    assign wordEq  = valReg[g][31:2] == fetchAddr[31:2];
    assign laneHit = wordEq && |(laneMask & fetchLanes);
    assign ctxEq   = valReg[g] == ctxId;
    assign linkOk  = (32'(linkIdx) < NUM_PAIRS) && ctxPad[linkIdx];

    assign ctxFlag[g] = slotOn && (kind == TY_CTX_SRC) && ctxEq &&
                        (privCode == 2'b11) && (laneMask == 4'b1111) &&
                        (ctlReg[g][15:14] == 2'b00);

    always_comb begin
      evtComb[g] = 1'b0;
      if (slotOn) begin
        case (kind)
          TY_ADDR:     evtComb[g] = wordEq && stateOk;
          TY_ADDR_LNK: evtComb[g] = wordEq && stateOk && linkOk;
          TY_CTX:      evtComb[g] = ctxEq && stateOk && (laneMask == 4'b1111);
          TY_MISS:     evtComb[g] = !laneHit && stateOk;
          TY_MISS_LNK: evtComb[g] = !laneHit && stateOk && linkOk;
          default:     evtComb[g] = 1'b0;
        endcase
      end
    end
  end

  assign ctxMatchOut = ctxFlag;

  always_ff @(posedge clk) begin
    if (rst) begin
      evtVec <= '0;
      evtAny <= 1'b0;
    end else if (strobes.capture) begin
      evtVec <= evtComb;
      evtAny <= |evtComb;
    end else begin
      evtVec <= '0;
      evtAny <= 1'b0;
    end
  end
endmodule

// File: rtl/bpMatchUnit.sv
module bpMatchUnit
  import bpMatchPkg::*;
#(
  parameter int NUM_PAIRS = 6,
  parameter int IDX_W     = $clog2(NUM_PAIRS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wrEn,
  input  logic                 wrCtl,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic [31:0]          wrData,
  input  logic                 fetchValid,
  input  logic [31:0]          fetchAddr,
  input  logic                 fetchSize,
  input  logic                 privMode,
  input  logic [31:0]          ctxId,
  output logic [NUM_PAIRS-1:0] evtVec,
  output logic                 evtAny,
  output logic [NUM_PAIRS-1:0] ctxMatchOut
);
  bpStrobe_t strobes;

  bpMatchCtrl #(.NUM_PAIRS(NUM_PAIRS), .IDX_W(IDX_W)) ctrl (
    .wrEn(wrEn), .wrCtl(wrCtl), .wrIdx(wrIdx),
    .fetchValid(fetchValid), .strobes(strobes)
  );

  bpMatchPath #(.NUM_PAIRS(NUM_PAIRS)) path (
    .clk(clk), .rst(rst), .strobes(strobes), .wrData(wrData),
    .fetchAddr(fetchAddr), .fetchSize(fetchSize), .privMode(privMode),
    .ctxId(ctxId), .evtVec(evtVec), .evtAny(evtAny),
    .ctxMatchOut(ctxMatchOut)
  );
endmodule

// File: rtl/bpMatchChk.sv
module bpMatchChk #(
  parameter int NUM_PAIRS = 6,
  parameter int IDX_W     = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wrEn,
  input logic                 wrCtl,
  input logic [IDX_W-1:0]     wrIdx,
  input logic [31:0]          wrData,
  input logic                 fetchValid,
  input logic [31:0]          ctxId,
  input logic [NUM_PAIRS-1:0] evtVec,
  input logic                 evtAny,
  input logic [NUM_PAIRS-1:0] ctxMatchOut
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (evtVec == '0 && !evtAny));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !fetchValid |=> (evtVec == '0 && !evtAny));

  // R13
  any_or_chk: assert property (@(posedge clk) disable iff (rst)
    evtAny == (|evtVec));

  // R2
  oob_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && 32'(wrIdx) >= NUM_PAIRS) |=>
      (!$stable(ctxId) || $stable(ctxMatchOut)));

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : gDis
    // R6
    disable_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (wrEn && wrCtl && wrIdx == IDX_W'(k) && !wrData[0]) |=> !ctxMatchOut[k]);
  end
endmodule

bind bpMatchUnit bpMatchChk #(.NUM_PAIRS(NUM_PAIRS), .IDX_W(IDX_W)) chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrCtl(wrCtl), .wrIdx(wrIdx),
  .wrData(wrData), .fetchValid(fetchValid), .ctxId(ctxId),
  .evtVec(evtVec), .evtAny(evtAny), .ctxMatchOut(ctxMatchOut)
);

// File: tb/bpMatchUnit_test.sv
`timescale 1ns/1ps
module bpMatchUnit_test;
  localparam int N = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0, wrCtl = 1'b0;
  logic [2:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic        fetchValid = 1'b0, fetchSize = 1'b1, privMode = 1'b0;
  logic [31:0] fetchAddr = '0, ctxId = '0;
  logic [N-1:0] evtVec, ctxMatchOut;
  logic         evtAny;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] sVal [N];
  logic [31:0] sCtl [N];

  always #2.5 clk = ~clk;

  bpMatchUnit uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrCtl(wrCtl), .wrIdx(wrIdx),
    .wrData(wrData), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .fetchSize(fetchSize), .privMode(privMode), .ctxId(ctxId),
    .evtVec(evtVec), .evtAny(evtAny), .ctxMatchOut(ctxMatchOut)
  );

  function automatic logic [31:0] mkCtl(int ty, int lnk, int lanes, int pr, int en);
    return (32'(ty) << 20) | (32'(lnk) << 16) | (32'(lanes) << 5) | (32'(pr) << 1) | 32'(en);
  endfunction

  function automatic bit expCtx(int j);
    if (j >= N) return 1'b0;
    return sCtl[j][0] && sCtl[j][22:20] == 3'd3 && sCtl[j][2:1] == 2'b11 &&
           sCtl[j][8:5] == 4'hF && sCtl[j][15:14] == 2'b00 && sVal[j] == ctxId;
  endfunction

  function automatic bit expEvt(int i);
    bit st, weq, lhit;
    logic [3:0] ln;
    int p = int'(sCtl[i][2:1]);
    int lk = int'(sCtl[i][19:16]);
    st = (p == 3) || (p == 1 && privMode) || (p == 2 && !privMode);
    weq = sVal[i][31:2] == fetchAddr[31:2];
    ln = fetchSize ? 4'hF : (fetchAddr[1] ? 4'hC : 4'h3);
    lhit = weq && ((ln & sCtl[i][8:5]) != 0);
    if (!sCtl[i][0]) return 1'b0;
    case (int'(sCtl[i][22:20]))
      0: return weq && st;
      1: return weq && st && expCtx(lk);
      2: return sVal[i] == ctxId && st && sCtl[i][8:5] == 4'hF;
      4: return !lhit && st;
      5: return !lhit && st && expCtx(lk);
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, bit isCtl, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrCtl = isCtl; wrIdx = 3'(idx); wrData = d;
    if (idx < N) begin
      if (isCtl) sCtl[idx] = d; else sVal[idx] = d;
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic fetchChk(logic [31:0] a, bit sz, bit pm, logic [31:0] cx, string req);
    logic [N-1:0] ev, cv;
    @(negedge clk);
    fetchAddr = a; fetchSize = sz; privMode = pm; ctxId = cx; fetchValid = 1'b1;
    for (int i = 0; i < N; i++) begin ev[i] = expEvt(i); cv[i] = expCtx(i); end
    @(negedge clk);
    fetchValid = 1'b0;
    check(evtVec == ev, req, 32'(evtVec), 32'(ev));
    check(evtAny == (|ev), "R13 any", 32'(evtAny), 32'(|ev));
    check(ctxMatchOut == cv, "R9 ctx flags", 32'(ctxMatchOut), 32'(cv));
    @(negedge clk);
    check(evtVec == '0 && !evtAny, "R3 idle", 32'(evtVec), 0);
  endtask

  function automatic string typeReq(int t);
    case (t)
      0: return "R4 type000";
      1: return "R7 type001";
      2: return "R8 type010";
      3: return "R9 type011";
      4: return "R10 type100";
      5: return "R11 type101";
      default: return "R12 reserved";
    endcase
  endfunction

  initial begin
    for (int i = 0; i < N; i++) begin sVal[i] = '0; sCtl[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(evtVec == '0 && !evtAny, "R1 reset events", 32'(evtVec), 0);
    check(ctxMatchOut == '0, "R1 reset flags", 32'(ctxMatchOut), 0);
    fetchChk(32'h0, 1'b1, 1'b1, 32'h0, "R1 cleared slots");

    // main sweep: slot 0 type/priv/enable, slot 1 is a context target
    wr(1, 1'b0, 32'h55);
    wr(1, 1'b1, mkCtl(3, 0, 15, 3, 1));
    wr(0, 1'b0, 32'h1230);
    for (int t = 0; t < 8; t++)
      for (int p = 0; p < 4; p++)
        for (int en = 0; en < 2; en++) begin
          wr(0, 1'b1, mkCtl(t, 1, 15, p, en));
          for (int pm = 0; pm < 2; pm++)
            for (int h = 0; h < 2; h++)
              for (int c = 0; c < 3; c++)
                fetchChk(h ? 32'h1232 : 32'h1240, 1'b1, pm[0],
                         c == 0 ? 32'h55 : (c == 1 ? 32'h1230 : 32'h99),
                         en ? (p == 3 ? typeReq(t) : "R5 priv") : "R6 disabled");
        end

    // lane-mask sweep on the miss type
    for (int b = 0; b < 16; b++) begin
      wr(0, 1'b1, mkCtl(4, 0, b, 3, 1));
      for (int sz = 0; sz < 2; sz++)
        for (int lo = 0; lo < 2; lo++)
          for (int h = 0; h < 2; h++)
            fetchChk((h ? 32'h1230 : 32'h2230) | (lo ? 32'h2 : 32'h0),
                     sz[0], 1'b0, 32'h1, "R10 lanes");
    end

    // link index sweep against slot 3 in several configurations
    wr(3, 1'b0, 32'h77);
    for (int v = 0; v < 5; v++) begin
      case (v)
        0: wr(3, 1'b1, mkCtl(3, 0, 15, 3, 1));
        1: wr(3, 1'b1, mkCtl(3, 0, 15, 3, 0));
        2: wr(3, 1'b1, mkCtl(3, 0, 15, 1, 1));
        3: wr(3, 1'b1, mkCtl(3, 0, 15, 3, 1) | 32'h4000);
        default: wr(3, 1'b1, mkCtl(3, 0, 7, 3, 1));
      endcase
      for (int l = 0; l < 16; l++) begin
        wr(0, 1'b1, mkCtl(1, l, 15, 3, 1));
        fetchChk(32'h1230, 1'b1, 1'b1, 32'h77, "R12 link");
        fetchChk(32'h1230, 1'b1, 1'b1, 32'h55, "R12 link");
      end
    end

    // out-of-range writes are ignored
    wr(0, 1'b1, mkCtl(0, 0, 15, 3, 1));
    wr(6, 1'b1, 32'h0);
    wr(7, 1'b0, 32'hFFFF_FFFF);
    wr(6, 1'b0, 32'h0);
    fetchChk(32'h1230, 1'b1, 1'b0, 32'h55, "R2 ignored write");
    fetchChk(32'h1230, 1'b1, 1'b0, 32'h77, "R2 ignored write");
    wr(2, 1'b0, 32'h88);
    wr(2, 1'b1, mkCtl(3, 0, 15, 3, 1));
    fetchChk(32'h0, 1'b1, 1'b0, 32'h88, "R2 write");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule